// File: doc/BRIEF.md
# Masked DMA Channel Control Register

This block holds the host-visible control and status state for a small group of DMA channels. Each channel has a 32-bit control word. Its upper half is a bit mask and its lower half carries new values, so software can change RUN, PAUSE and WAKE, or start a FLUSH, without a read-modify-write. After each control update the block recomputes the channel's ACTIVE bit from fixed priority rules. A stop forces a flush handshake with the attached device before the new status takes effect. Whenever the committed status leaves the channel active, the block sends a one-cycle kick to the descriptor sequencer.

The block also decodes the register window of each channel. That window holds the command pointer, three condition-select registers (interrupt, branch and wait) and the status register. The descriptor sequencer sits outside the block and reports its events through side inputs: channel died, command stopped, branch taken or not, and command fetched. Those events change DEAD, ACTIVE, BT and WAKE.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every channel reads status 0, command pointer 0 and select registers 0. flush_req, kick and fetch are low, and bus_ready is high.
- R2: Status layout (bits 31:16 read 0): 15 RUN, 14 PAUSE, 13 FLUSH, 12 WAKE, 11 DEAD, 10 ACTIVE, 9 zero, 8 BT, 7:0 the channel's dev_stat input zero-extended. A control write changes only bits whose mask bit (write data bit 16+n) is set. RUN under the mask takes the written value, and writing RUN=0 also clears DEAD.
- R3: WAKE=1 under the mask sets WAKE only if RUN is set once the RUN part of the same write has been applied.
- R4: PAUSE under the mask is replaced by the written PAUSE value.
- R5: If the result has PAUSE=1 or RUN=0, ACTIVE becomes 0. Otherwise ACTIVE becomes 1 if RUN or PAUSE was in the mask, or if WAKE=1 was written under the mask, and is left unchanged in all other cases.
- R6: A control write that writes FLUSH=1 under the mask, or whose result has PAUSE=1 or RUN=0, raises flush_req from the next cycle and holds the status update. FLUSH reads 1 during that wait only when it was written explicitly. The update is applied, with FLUSH=0, on the edge where flush_ack is high, and flush_req drops after that edge.
- R7: bus_ready is low while any channel's flush is pending. No access is accepted during that time.
- R8: kick pulses for exactly one cycle after a committed control update whose final status has ACTIVE=1.
- R9: A write to the command pointer (word 3) is ignored while ACTIVE=1. An accepted write stores the data with bits 3:0 forced to 0 and pulses fetch for one cycle.
- R10: Sequencer inputs act after any control update in the same cycle. seq_fetched clears WAKE. seq_bt_set sets BT, and seq_bt_clr clears it unless seq_bt_set is also high. seq_dead sets DEAD and clears ACTIVE. seq_stop clears ACTIVE.
- R11: Read data is returned with rd_valid one cycle after the read is accepted. Words 0 and 1 read status, word 3 reads the command pointer, and words 4, 5 and 6 read the interrupt, branch and wait selects. A select keeps only its mask field (bits 19:16) and value field (bits 3:0). All other words read 0.
- R12: An access with bus_be other than 4'hF, with address bits 1:0 not zero, or with a channel field at or above NCH has no effect, and a read of that kind returns 0.
- R13: The channel is taken from address bits ADDR_W-1:CH_SHIFT and the word from bits CH_SHIFT-1:2. An access to one channel leaves every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: channel and word |
| bus_be | input | 4 | Byte enables; only 4'hF is honoured |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access accepted when high with bus_valid |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| flush_req | output | NCH | Per-channel device flush request |
| flush_ack | input | NCH | Device flush done |
| kick | output | NCH | Start pulse to the sequencer |
| fetch | output | NCH | Descriptor fetch pulse after a pointer write |
| cmd_ptr | output | 32*NCH | Command pointers |
| chan_status | output | 16*NCH | Live status words |
| cond_sel | output | 6*SEL_W*NCH | Per channel {wait, branch, intr} selects, each {mask, value} |
| dev_stat | input | DEV_W*NCH | Device condition bits per channel |
| seq_dead | input | NCH | Sequencer marks the channel dead |
| seq_stop | input | NCH | Sequencer reached a stop command |
| seq_bt_set | input | NCH | Branch taken |
| seq_bt_clr | input | NCH | Sequential advance |
| seq_fetched | input | NCH | Command fetched, clears WAKE |

## Verification
The hardest state to reach is the window between a stopping or flushing control write and the device's acknowledge. In that window the bus is stalled, FLUSH may or may not be visible, and the final status depends on the state at commit time. The bench's device responder waits a programmable number of cycles before it acknowledges. Stimulus therefore lands in that window with the responder set to several delays, and queues a second access behind it. DEAD is set through the sequencer input and then cleared by a RUN=0 write that itself needs a flush. That is the only path that checks the DEAD clearing.

// File: rtl/dmacc_pkg.sv
`timescale 1ns/1ps
package dmacc_pkg;

   localparam int S_RUN    = 15;
   localparam int S_PAUSE  = 14;
   localparam int S_FLUSH  = 13;
   localparam int S_WAKE   = 12;
   localparam int S_DEAD   = 11;
   localparam int S_ACTIVE = 10;
   localparam int S_BT     = 8;

   localparam int IX_CTL   = 0;
   localparam int IX_STAT  = 1;
   localparam int IX_PTR   = 3;
   localparam int IX_SEL0  = 4;
   localparam int NUM_SEL  = 3;

   typedef struct packed {
      logic run;
      logic pause;
      logic flush;
      logic wake;
      logic dead;
      logic active;
      logic bt;
   } chst_t;

   // masked update of the control bits; ACTIVE re-derived by priority
   function automatic chst_t ctl_apply(chst_t s, logic [15:0] m, logic [15:0] v);
      chst_t r;
      r = s;
      if (m[S_RUN]) begin
         r.run = v[S_RUN];
         if (!v[S_RUN]) r.dead = 1'b0;
      end
      if (m[S_WAKE] && v[S_WAKE] && r.run) r.wake = 1'b1;
      if (m[S_PAUSE]) r.pause = v[S_PAUSE];
      if (r.pause || !r.run)
         r.active = 1'b0;
      else if (m[S_RUN] || m[S_PAUSE] || (m[S_WAKE] && v[S_WAKE]))
         r.active = 1'b1;
      r.flush = 1'b0;
      return r;
   endfunction

   function automatic logic flush_needed(chst_t r, logic [15:0] m, logic [15:0] v);
      return (m[S_FLUSH] && v[S_FLUSH]) || r.pause || !r.run;
   endfunction

endpackage

// File: rtl/dmacc_decode.sv
`timescale 1ns/1ps
module dmacc_decode #(
   parameter int NCH      = 2,
   parameter int ADDR_W   = 12,
   parameter int CH_SHIFT = 8,
   localparam int CH_W    = ADDR_W - CH_SHIFT,
   localparam int IX_W    = CH_SHIFT - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              ready,
   input  logic              write,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        be,
   output logic              rd_acc,
   output logic              legal,
   output logic [NCH-1:0]    ch_oh,
   output logic [NCH-1:0]    wr_oh,
   output logic [IX_W-1:0]   ix
);

   logic [CH_W-1:0] ch_idx;
   logic            acc;

   assign ch_idx = addr[ADDR_W-1:CH_SHIFT];
   assign ix     = addr[CH_SHIFT-1:2];
   assign acc    = valid && ready;
   assign legal  = (be == 4'hF) && (addr[1:0] == 2'b00) && (int'(ch_idx) < NCH);
   assign rd_acc = acc && !write;

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign ch_oh[c] = legal && (int'(ch_idx) == c);
      assign wr_oh[c] = acc && write && ch_oh[c];
   end

   // R13
   one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ch_oh));

endmodule

// File: rtl/dmacc_chan.sv
`timescale 1ns/1ps
module dmacc_chan
   import dmacc_pkg::*;
#(
   parameter int IX_W  = 6,
   parameter int DEV_W = 4,
   parameter int SEL_W = 4,
   localparam int SF   = 2 * SEL_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [IX_W-1:0]            ix,
   input  logic [31:0]                wdata,
   input  logic [DEV_W-1:0]           dev,
   input  logic                       seq_dead,
   input  logic                       seq_stop,
   input  logic                       seq_bt_set,
   input  logic                       seq_bt_clr,
   input  logic                       seq_fetched,
   input  logic                       flush_ack,
   output logic                       flush_req,
   output logic                       kick,
   output logic                       fetch,
   output logic [31:0]                ptr,
   output logic [15:0]                status,
   output logic [NUM_SEL*SF-1:0]      sel_o,
   output logic [31:0]                rd_word
);

   chst_t       st_q, st_n, st_wr, st_com;
   logic        pend_q;
   logic [15:0] pm_q, pv_q;
   logic [27:0] ptr_q;
   logic        kick_q, fetch_q;
   logic        wr_ctl, wr_ptr, commit, need_fl, kick_n;

   assign wr_ctl = wr_en && (ix == IX_W'(IX_CTL));
   assign wr_ptr = wr_en && (ix == IX_W'(IX_PTR)) && !st_q.active;
   assign commit = pend_q && flush_ack;

   always_comb begin
      st_wr   = ctl_apply(st_q, wdata[31:16], wdata[15:0]);
      st_com  = ctl_apply(st_q, pm_q, pv_q);
      need_fl = flush_needed(st_wr, wdata[31:16], wdata[15:0]);
      st_n    = st_q;
      if (commit)
         st_n = st_com;
      else if (wr_ctl && !need_fl)
         st_n = st_wr;
      else if (wr_ctl && wdata[16+S_FLUSH] && wdata[S_FLUSH])
         st_n.flush = 1'b1;
      // sequencer events act on top of the control result
      if (seq_fetched) st_n.wake = 1'b0;
      if (seq_bt_set)
         st_n.bt = 1'b1;
      else if (seq_bt_clr)
         st_n.bt = 1'b0;
      if (seq_dead) begin
         st_n.dead   = 1'b1;
         st_n.active = 1'b0;
      end
      if (seq_stop) st_n.active = 1'b0;
      kick_n = (commit || (wr_ctl && !need_fl)) && st_n.active;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         pend_q  <= 1'b0;
         pm_q    <= '0;
         pv_q    <= '0;
         ptr_q   <= '0;
         kick_q  <= 1'b0;
         fetch_q <= 1'b0;
      end else begin
         st_q    <= st_n;
         kick_q  <= kick_n;
         fetch_q <= wr_ptr;
         if (commit)
            pend_q <= 1'b0;
         else if (wr_ctl && need_fl) begin
            pend_q <= 1'b1;
            pm_q   <= wdata[31:16];
            pv_q   <= wdata[15:0];
         end
         if (wr_ptr) ptr_q <= wdata[31:4];
      end
   end

   for (genvar k = 0; k < NUM_SEL; k++) begin : g_csel
      logic [SF-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r <= '0;
         else if (wr_en && (ix == IX_W'(IX_SEL0 + k)))
            r <= {wdata[16 +: SEL_W], wdata[0 +: SEL_W]};
      end
      assign sel_o[k*SF +: SF] = r;
   end

   assign status    = {st_q.run, st_q.pause, st_q.flush, st_q.wake, st_q.dead,
                       st_q.active, 1'b0, st_q.bt, 8'(dev)};
   assign ptr       = {ptr_q, 4'h0};
   assign flush_req = pend_q;
   assign kick      = kick_q;
   assign fetch     = fetch_q;

   always_comb begin
      rd_word = '0;
      if (ix == IX_W'(IX_CTL) || ix == IX_W'(IX_STAT))
         rd_word = {16'h0, status};
      else if (ix == IX_W'(IX_PTR))
         rd_word = ptr;
      else
         for (int k = 0; k < NUM_SEL; k++)
            if (ix == IX_W'(IX_SEL0 + k)) begin
               rd_word[16 +: SEL_W] = sel_o[k*SF + SEL_W +: SEL_W];
               rd_word[0 +: SEL_W]  = sel_o[k*SF +: SEL_W];
            end
   end

   // R9
   ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.active && wr_en && ix == IX_W'(IX_PTR)) |=> $stable(ptr));
   // R6
   flush_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q.flush |-> pend_q);
   // R5
   active_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_q.active |-> (st_q.run && !st_q.pause));
   // R8
   kick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kick_q |-> $past(commit || (wr_ctl && !need_fl)));

endmodule

// File: rtl/dmacc_readback.sv
`timescale 1ns/1ps
module dmacc_readback #(
   parameter int NCH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_acc,
   input  logic              legal,
   input  logic [NCH-1:0]    ch_oh,
   input  logic [NCH*32-1:0] words,
   output logic              rd_valid,
   output logic [31:0]       rd_data
);

   logic [31:0] pick;

   always_comb begin
      pick = '0;
      for (int c = 0; c < NCH; c++)
         if (ch_oh[c]) pick = words[c*32 +: 32];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_acc;
         rd_data  <= (rd_acc && legal) ? pick : 32'h0;
      end
   end

endmodule

// File: rtl/dma_chan_ctl.sv
`timescale 1ns/1ps
module dma_chan_ctl #(
   parameter int NCH      = 2,
   parameter int ADDR_W   = 12,
   parameter int CH_SHIFT = 8,
   parameter int DEV_W    = 4,
   parameter int SEL_W    = 4,
   localparam int IX_W    = CH_SHIFT - 2,
   localparam int SELS_W  = 6 * SEL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_valid,
   input  logic                    bus_write,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [3:0]              bus_be,
   input  logic [31:0]             bus_wdata,
   output logic                    bus_ready,
   output logic                    rd_valid,
   output logic [31:0]             rd_data,
   output logic [NCH-1:0]          flush_req,
   input  logic [NCH-1:0]          flush_ack,
   output logic [NCH-1:0]          kick,
   output logic [NCH-1:0]          fetch,
   output logic [NCH*32-1:0]       cmd_ptr,
   output logic [NCH*16-1:0]       chan_status,
   output logic [NCH*SELS_W-1:0]   cond_sel,
   input  logic [NCH*DEV_W-1:0]    dev_stat,
   input  logic [NCH-1:0]          seq_dead,
   input  logic [NCH-1:0]          seq_stop,
   input  logic [NCH-1:0]          seq_bt_set,
   input  logic [NCH-1:0]          seq_bt_clr,
   input  logic [NCH-1:0]          seq_fetched
);

   if (CH_SHIFT < 5 || CH_SHIFT >= ADDR_W) begin : g_bad_shift
      $error("CH_SHIFT must leave room for 8 words and a channel field");
   end
   if ((1 << (ADDR_W - CH_SHIFT)) < NCH) begin : g_bad_nch
      $error("channel field too narrow for NCH");
   end
   if (DEV_W < 1 || DEV_W > 8 || SEL_W < 1 || SEL_W > 16) begin : g_bad_fields
      $error("DEV_W must be 1..8 and SEL_W 1..16");
   end

   logic              rd_acc, legal;
   logic [NCH-1:0]    ch_oh, wr_oh;
   logic [IX_W-1:0]   ix;
   logic [NCH*32-1:0] words;

   assign bus_ready = ~|flush_req;

   dmacc_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .CH_SHIFT(CH_SHIFT)) u_dec (
      .clk(clk), .rst_n(rst_n), .valid(bus_valid), .ready(bus_ready),
      .write(bus_write), .addr(bus_addr), .be(bus_be), .rd_acc(rd_acc),
      .legal(legal), .ch_oh(ch_oh), .wr_oh(wr_oh), .ix(ix));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dmacc_chan #(.IX_W(IX_W), .DEV_W(DEV_W), .SEL_W(SEL_W)) u_ch (
         .clk(clk), .rst_n(rst_n), .wr_en(wr_oh[c]), .ix(ix), .wdata(bus_wdata),
         .dev(dev_stat[c*DEV_W +: DEV_W]), .seq_dead(seq_dead[c]),
         .seq_stop(seq_stop[c]), .seq_bt_set(seq_bt_set[c]),
         .seq_bt_clr(seq_bt_clr[c]), .seq_fetched(seq_fetched[c]),
         .flush_ack(flush_ack[c]), .flush_req(flush_req[c]), .kick(kick[c]),
         .fetch(fetch[c]), .ptr(cmd_ptr[c*32 +: 32]),
         .status(chan_status[c*16 +: 16]), .sel_o(cond_sel[c*SELS_W +: SELS_W]),
         .rd_word(words[c*32 +: 32]));
   end

   dmacc_readback #(.NCH(NCH)) u_rb (
      .clk(clk), .rst_n(rst_n), .rd_acc(rd_acc), .legal(legal), .ch_oh(ch_oh),
      .words(words), .rd_valid(rd_valid), .rd_data(rd_data));

   // R7
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|flush_req) |-> !bus_ready);
   // R11
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_ready && !bus_write) |=> rd_valid);

endmodule

// File: tb/sim_dma_chan_ctl.sv
`timescale 1ns/1ps
module sim_dma_chan_ctl;

   localparam int NCH = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic             bus_valid = 0, bus_write = 0;
   logic [11:0]      bus_addr = '0;
   logic [3:0]       bus_be = 4'hF;
   logic [31:0]      bus_wdata = '0;
   logic             bus_ready, rd_valid;
   logic [31:0]      rd_data;
   logic [NCH-1:0]   flush_req, kick, fetch;
   logic [NCH-1:0]   flush_ack = '0;
   logic [NCH*32-1:0] cmd_ptr;
   logic [NCH*16-1:0] chan_status;
   logic [NCH*24-1:0] cond_sel;
   logic [NCH*4-1:0]  dev_stat = 8'h50;
   logic [NCH-1:0]   seq_dead = '0, seq_stop = '0, seq_bt_set = '0,
                     seq_bt_clr = '0, seq_fetched = '0;

   dma_chan_ctl u0 (.*);

   int nchk = 0, nbad = 0, ack_dly = 2;
   bit done = 0;
   int acnt [NCH];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [15:0] m_st   [NCH];
   logic        m_pend [NCH];
   logic [15:0] m_pm [NCH], m_pv [NCH];
   logic [31:0] m_ptr [NCH];
   logic [31:0] m_sel [NCH][3];
   logic        m_kick [NCH], m_fetch [NCH];
   logic        m_rdv;
   logic [31:0] m_rdd;

   function automatic logic [15:0] mdl_ctl(logic [15:0] s, logic [15:0] m, logic [15:0] v);
      logic [15:0] r = s;
      if (m[15]) begin
         r[15] = v[15];
         if (!v[15]) r[11] = 0;
      end
      if (m[12] && v[12] && r[15]) r[12] = 1;
      if (m[14]) r[14] = v[14];
      if (r[14] || !r[15]) r[10] = 0;
      else if (m[15] || m[14] || (m[12] && v[12])) r[10] = 1;
      r[13] = 0;
      return r;
   endfunction

   function automatic logic [31:0] mdl_rd(int c, int w);
      if (w == 0 || w == 1) return {16'h0, m_st[c] | {12'h0, dev_stat[c*4 +: 4]}};
      if (w == 3) return m_ptr[c];
      if (w >= 4 && w <= 6) return m_sel[c][w-4];
      return 32'h0;
   endfunction

   task automatic mdl_reset();
      for (int c = 0; c < NCH; c++) begin
         m_st[c] = 0; m_pend[c] = 0; m_pm[c] = 0; m_pv[c] = 0; m_ptr[c] = 0;
         m_kick[c] = 0; m_fetch[c] = 0;
         for (int k = 0; k < 3; k++) m_sel[c][k] = 0;
      end
      m_rdv = 0; m_rdd = 0;
   endtask

   initial mdl_reset();

   always @(posedge clk) begin
      if (!rst_n) mdl_reset();
      else begin
         logic rdy, acc, ok, wr, k;
         int ch, w;
         logic [15:0] st, nw, hi, lo;
         rdy = 1;
         for (int c = 0; c < NCH; c++) if (m_pend[c]) rdy = 0;
         acc = bus_valid && rdy;
         ch  = int'(bus_addr[11:8]);
         w   = int'(bus_addr[7:2]);
         ok  = (bus_be == 4'hF) && (bus_addr[1:0] == 0) && (ch < NCH);
         hi  = bus_wdata[31:16];
         lo  = bus_wdata[15:0];
         m_rdv = acc && !bus_write;
         m_rdd = (acc && !bus_write && ok) ? mdl_rd(ch, w) : 32'h0;
         for (int c = 0; c < NCH; c++) begin
            k = 0;
            st = m_st[c];
            wr = acc && bus_write && ok && (ch == c);
            m_fetch[c] = 0;
            if (m_pend[c] && flush_ack[c]) begin
               st = mdl_ctl(st, m_pm[c], m_pv[c]);
               m_pend[c] = 0;
               k = 1;
            end else if (wr && w == 0) begin
               nw = mdl_ctl(st, hi, lo);
               if ((hi[13] && lo[13]) || nw[14] || !nw[15]) begin
                  m_pend[c] = 1; m_pm[c] = hi; m_pv[c] = lo;
                  if (hi[13] && lo[13]) st[13] = 1;
               end else begin
                  st = nw;
                  k = 1;
               end
            end else if (wr && w == 3 && !st[10]) begin
               m_ptr[c] = bus_wdata & 32'hFFFF_FFF0;
               m_fetch[c] = 1;
            end else if (wr && w >= 4 && w <= 6)
               m_sel[c][w-4] = bus_wdata & 32'h000F_000F;
            if (seq_fetched[c]) st[12] = 0;
            if (seq_bt_set[c]) st[8] = 1;
            else if (seq_bt_clr[c]) st[8] = 0;
            if (seq_dead[c]) begin st[11] = 1; st[10] = 0; end
            if (seq_stop[c]) st[10] = 0;
            m_kick[c] = k && st[10];
            m_st[c] = st;
         end
      end
   end

   // per-clock comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic any;
         any = 0;
         for (int c = 0; c < NCH; c++) begin
            chk("R2 status", {16'h0, chan_status[c*16 +: 16]},
                {16'h0, m_st[c] | {12'h0, dev_stat[c*4 +: 4]}});
            chk("R6 flush_req", {31'h0, flush_req[c]}, {31'h0, m_pend[c]});
            chk("R8 kick", {31'h0, kick[c]}, {31'h0, m_kick[c]});
            chk("R9 fetch", {31'h0, fetch[c]}, {31'h0, m_fetch[c]});
            chk("R9 cmd_ptr", cmd_ptr[c*32 +: 32], m_ptr[c]);
            any |= m_pend[c];
         end
         chk("R7 bus_ready", {31'h0, bus_ready}, {31'h0, !any});
         chk("R11 rd_valid", {31'h0, rd_valid}, {31'h0, m_rdv});
         if (m_rdv) chk("R11 rd_data", rd_data, m_rdd);
      end
   end

   // device flush responder with programmable delay
   always @(negedge clk) begin
      for (int c = 0; c < NCH; c++) begin
         if (!flush_req[c]) begin
            flush_ack[c] = 0;
            acnt[c] = 0;
         end else if (acnt[c] >= ack_dly)
            flush_ack[c] = 1;
         else
            acnt[c] = acnt[c] + 1;
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
      @(negedge clk);
      while (!bus_ready) @(negedge clk);
      bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_valid = 0; bus_write = 0; bus_be = 4'hF;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      while (!bus_ready) @(negedge clk);
      bus_valid = 1; bus_write = 0; bus_addr = a; bus_be = be;
      @(negedge clk);
      bus_valid = 0; bus_be = 4'hF;
      d = rd_data;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!bus_ready) @(negedge clk);
   endtask

   task automatic side(int c, int which);
      @(negedge clk);
      case (which)
         0: seq_dead[c] = 1;
         1: seq_stop[c] = 1;
         2: seq_bt_set[c] = 1;
         3: seq_bt_clr[c] = 1;
         default: seq_fetched[c] = 1;
      endcase
      @(negedge clk);
      seq_dead = '0; seq_stop = '0; seq_bt_set = '0; seq_bt_clr = '0; seq_fetched = '0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status0", {16'h0, chan_status[15:0]}, 32'h0);
      chk("R1 flush", {30'h0, flush_req}, 32'h0);
      chk("R1 kick", {30'h0, kick}, 32'h0);
      chk("R1 ready", {31'h0, bus_ready}, 32'h1);
      rd(12'h010, d); chk("R1 sel", d, 32'h0);

      // R9 pointer alignment, R11 selects
      wr(12'h00C, 32'h1234_5678);
      rd(12'h00C, d); chk("R9 ptr align", d, 32'h1234_5670);
      wr(12'h010, 32'hFFFF_FFFF);
      rd(12'h010, d); chk("R11 sel fields", d, 32'h000F_000F);
      wr(12'h014, 32'h00A5_0003);
      rd(12'h014, d); chk("R11 branch sel", d, 32'h0005_0003);

      // R5 run -> active, R8 kick
      wr(12'h000, 32'h8000_8000);
      chk("R8 kick high", {31'h0, kick[0]}, 32'h1);
      @(negedge clk);
      chk("R8 kick one cycle", {31'h0, kick[0]}, 32'h0);
      rd(12'h000, d); chk("R5 active", d, 32'h0000_8400);
      rd(12'h004, d); chk("R11 status word", d, 32'h0000_8400);
      wr(12'h00C, 32'hAAAA_0000);
      rd(12'h00C, d); chk("R9 ignored when active", d, 32'h1234_5670);

      // R3 wake with run, R10 side events
      wr(12'h000, 32'h1000_1000);
      rd(12'h000, d); chk("R3 wake set", d, 32'h0000_9400);
      side(0, 4);
      rd(12'h000, d); chk("R10 fetched clears wake", d, 32'h0000_8400);
      side(0, 2);
      rd(12'h000, d); chk("R10 bt set", d, 32'h0000_8500);

      // R4 pause via stop-flush, R6 FLUSH not visible
      wr(12'h000, 32'h4000_4000);
      chk("R6 flush_req on pause", {31'h0, flush_req[0]}, 32'h1);
      chk("R6 flush hidden", {16'h0, chan_status[15:0]}, 32'h0000_8500);
      chk("R7 stalled", {31'h0, bus_ready}, 32'h0);
      wait_idle();
      rd(12'h000, d); chk("R4 paused", d, 32'h0000_C100);
      wr(12'h000, 32'h4000_0000);
      rd(12'h000, d); chk("R5 unpause active", d, 32'h0000_8500);

      // R6 explicit flush visible while pending
      ack_dly = 4;
      wr(12'h000, 32'h2000_2000);
      chk("R6 flush visible", {16'h0, chan_status[15:0]}, 32'h0000_A500);
      wait_idle();
      rd(12'h000, d); chk("R6 flush cleared", d, 32'h0000_8500);

      // R10 dead, R2 run clear clears dead
      side(0, 0);
      rd(12'h000, d); chk("R10 dead", d, 32'h0000_8900);
      wr(12'h000, 32'h8000_0000);
      wait_idle();
      rd(12'h000, d); chk("R2 dead cleared", d, 32'h0000_0100);
      wr(12'h000, 32'h0000_FFFF);
      wait_idle();
      rd(12'h000, d); chk("R2 mask zero", d, 32'h0000_0100);
      wr(12'h000, 32'h1000_1000);
      wait_idle();
      rd(12'h000, d); chk("R3 wake needs run", d, 32'h0000_0100);
      side(0, 3);
      rd(12'h000, d); chk("R10 bt clr", d, 32'h0);

      // R12 illegal accesses
      wr(12'h000, 32'h8000_8000, 4'h3);
      chk("R12 partial write", {16'h0, chan_status[15:0]}, 32'h0);
      rd(12'h00C, d, 4'h1); chk("R12 partial read", d, 32'h0);
      rd(12'h00D, d); chk("R12 misaligned", d, 32'h0);
      rd(12'h20C, d); chk("R12 no channel", d, 32'h0);

      // R13 second channel
      wr(12'h100, 32'h8000_8000);
      rd(12'h104, d); chk("R13 ch1 status", d, 32'h0000_8405);
      chk("R13 ch0 untouched", {16'h0, chan_status[15:0]}, 32'h0);
      rd(12'h108, d); chk("R11 unused word", d, 32'h0);
      rd(12'h11C, d); chk("R11 reserved word", d, 32'h0);
      side(1, 1);
      rd(12'h100, d); chk("R10 stop", d, 32'h0000_8005);
      wr(12'h100, 32'h1000_1000);
      chk("R8 kick on wake", {31'h0, kick[1]}, 32'h1);
      rd(12'h100, d); chk("R5 wake reactivates", d, 32'h0000_9405);

      // R7 access queued behind a pending flush
      ack_dly = 6;
      wr(12'h100, 32'h2000_2000);
      chk("R7 ready low", {31'h0, bus_ready}, 32'h0);
      wr(12'h00C, 32'h0000_0047);
      chk("R7 flush done first", {30'h0, flush_req}, 32'h0);
      rd(12'h00C, d); chk("R7 queued write", d, 32'h0000_0040);

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule